// File: doc/BRIEF.md
# SPI Master Transfer Sequencer

This block runs the byte-level timing of a serial peripheral interface master. A free-running counter on the system clock produces an internal serial clock at one of four division ratios. An eleven-state sequencer gates that clock onto the output pin, shifts each byte out on MOSI with the most significant bit first, and drives eight active-low slave-select lines. It keeps a minimum setup time before the first clock edge, a minimum hold time after the last one, and a minimum deassertion gap between transfers.

The surrounding register logic supplies the transmit byte, an "empty" flag for the transmit holding register, the start request, the clock mode and the slave mask. Each time the sequencer copies the holding register into its shift register, it pulses `load_taken`. The surrounding logic answers by raising `xmit_empty` or by presenting the next byte. When the contention input goes low, the sequencer abandons the transfer and stops driving every bus pin. Sampling of MISO belongs to a separate block.

Top module: `spi_xfer_seq`

## Requirements
- R1: `div_sel` values 0, 1, 2 and 3 give a serial clock period of 4, 8, 16 and 32 system clocks.
- R2: When no byte is being shifted, `sck` rests at the `cpol` level. It toggles only during a byte, and each byte produces exactly 8 full periods.
- R3: A transfer begins only while `start`=1, `xmit_empty`=0 and `contend_n`=1. If any of these is missing, the select lines stay high and `load_taken` stays low.
- R4: Bits leave MSB first, 8 per byte. With `cpha`=0 the slave samples on the edge away from the `cpol` level. With `cpha`=1 it samples on the edge back to the `cpol` level.
- R5: A select line goes low at least one serial clock period before the first `sck` edge, and `ss_n` never changes in the same cycle as `sck`.
- R6: After the last `sck` edge of a burst, the select line stays low for at least two periods. After it goes high, it stays high for at least one period before it can go low again.
- R7: With `cpha`=1, bytes that follow back to back share one select-low window. With `cpha`=0, the select line goes high and low again between bytes.
- R8: `load_taken` is a single-cycle pulse, issued once for each byte copied from `tx_byte`.
- R9: `done` goes to 1 after the eighth bit of a byte and returns to 0 when the next byte is loaded. `busy` is 1 while any select line is driven low.
- R10: `ss_n[i]` is low only when bit i of `ss_mask` is 1 and a transfer is active. If several mask bits are set, several lines go low together.
- R11: One cycle after `contend_n` goes low, `sck_oe`, `mosi_oe` and `ss_oe` are all 0 and the sequencer is idle. It stays idle until `contend_n` is released and `start` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Keep transferring while high |
| xmit_empty | input | 1 | Transmit holding register holds no byte |
| cpol | input | 1 | Idle level of `sck` |
| cpha | input | 1 | Clock phase mode |
| div_sel | input | 2 | Serial clock divider select |
| ss_mask | input | 8 | Slave select enable per line |
| tx_byte | input | 8 | Byte to transmit |
| contend_n | input | 1 | Low when another master drives the bus |
| load_taken | output | 1 | Pulse: `tx_byte` copied into the shift register |
| done | output | 1 | Last byte fully shifted |
| busy | output | 1 | A select line is asserted |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 8 | Active-low slave selects |
| sck_oe | output | 1 | Output enable for `sck` |
| mosi_oe | output | 1 | Output enable for `mosi` |
| ss_oe | output | 1 | Output enable for `ss_n` |

## Verification
Some properties are checked on every cycle. `sck` and `ss_n` never move in the same cycle. `load_taken` never lasts longer than one cycle. A byte ends only after its eighth shift. The sequencer leaves idle only with start, data and a free bus. Contention disables all output drivers one cycle later and forces the sequencer idle. Other behaviours can only be shown by the directed scenarios: the actual bit stream seen at the sampling edge in each of the four modes, the measured clock periods, the minimum setup, hold and gap times, and whether the select stays low or is released between bytes.

// File: rtl/spi_seq_pkg.sv
// Shared types for the SPI master transfer sequencer.
// Assumes: nothing beyond the system clock domain.
package spi_seq_pkg;

    // Sequencer states, in the order a transfer visits them.
    typedef enum logic [3:0] {
        S_IDLE,     // bus released, waiting for start and data
        S_LEAD_A,   // select asserted, wait internal rise
        S_LEAD_B,   // select asserted, wait internal fall
        S_ARM,      // byte loaded, phase-1 clock unmasked
        S_SHIFT,    // phase-0 clock unmasked, shifting bits
        S_MARK,     // byte finished, flag done
        S_DECIDE,   // continue in place or wind down
        S_QUIET,    // clock masked, start of hold
        S_TAIL_A,   // select hold, first period
        S_TAIL_B,   // select hold, second period
        S_GAP       // select released, minimum high time
    } seq_state_t;

endpackage

// File: rtl/spi_sck_div.sv
// Serial clock divider. A free-running counter produces the internal
// serial clock, plus one-cycle event pulses that mark the cycle before
// each internal rising and falling edge.
// Assumes: div_sel stays steady while a transfer is in progress.
module spi_sck_div #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    output logic             sck_int,
    output logic             rise_evt,
    output logic             fall_evt
);
    localparam int CNT_W = (1 << SEL_W) + 1;
    localparam int IDX_W = $clog2(CNT_W);

    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] bit_idx;
    logic [CNT_W-1:0] lo_mask;
    logic             lo_full;

    // Free-running divider counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // Select the counter bit for the chosen rate and find the wrap points below it.
    always_comb begin
        bit_idx  = IDX_W'(div_sel) + IDX_W'(1);
        lo_mask  = (CNT_W'(1) << bit_idx) - CNT_W'(1);
        lo_full  = (cnt & lo_mask) == lo_mask;
        sck_int  = cnt[bit_idx];
        rise_evt = lo_full && !cnt[bit_idx];
        fall_evt = lo_full && cnt[bit_idx];
    end

    // A rise event is followed by a high internal clock unless the rate changed.
    assert_rise_then_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> (sck_int || div_sel != $past(div_sel)));
    assert_fall_then_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> (!sck_int || div_sel != $past(div_sel)));

endmodule

// File: rtl/spi_tx_shift.sv
// Transmit shift register. It loads a parallel byte and shifts left one
// place per shift request. The MSB is the serial output.
// Assumes: load and shift requests are never asserted together.
module spi_tx_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] din,
    output logic         sout
);
    logic [W-1:0] sreg;

    // Load a new byte, or move the next bit into the MSB position.
    always_ff @(posedge clk) begin
        if (!rst_n)     sreg <= '0;
        else if (load)  sreg <= din;
        else if (shift) sreg <= {sreg[W-2:0], 1'b0};
    end

    assign sout = sreg[W-1];

    assert_no_load_shift_clash_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));

endmodule

// File: rtl/spi_seq_fsm.sv
// Transfer sequencer. Walks the select setup, the byte shift, the
// continue-or-stop decision and the select hold and gap. It advances
// only on the divider's event pulses.
// Assumes: rise/fall events are one-cycle pulses from spi_sck_div.
module spi_seq_fsm
    import spi_seq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       xmit_empty,
    input  logic       contend_n,
    input  logic       cpha,
    input  logic       rise_evt,
    input  logic       fall_evt,
    output seq_state_t state,
    output logic       load_en,
    output logic       shift_en,
    output logic       ss_act,
    output logic       mask_ph0,
    output logic       mask_ph1,
    output logic       done
);
    localparam int BC_W = $clog2(W);
    localparam logic [BC_W-1:0] LAST = BC_W'(W - 1);

    seq_state_t      nxt;
    logic [BC_W-1:0] bit_cnt;

    // Next-state logic. Contention overrides every other condition.
    always_comb begin
        nxt      = state;
        load_en  = 1'b0;
        shift_en = 1'b0;
        if (!contend_n) begin
            nxt = S_IDLE;
        end else begin
            case (state)
                S_IDLE:   if (start && !xmit_empty) nxt = S_LEAD_A;
                S_LEAD_A: if (rise_evt) nxt = S_LEAD_B;
                S_LEAD_B: if (fall_evt) begin
                              nxt     = S_ARM;
                              load_en = 1'b1;
                          end
                S_ARM:    if (rise_evt) nxt = S_SHIFT;
                S_SHIFT:  if (rise_evt) begin
                              shift_en = 1'b1;
                              if (bit_cnt == LAST) nxt = S_MARK;
                          end
                S_MARK:   if (fall_evt) nxt = S_DECIDE;
                S_DECIDE: if (start && cpha && !xmit_empty) begin
                              nxt     = S_ARM;
                              load_en = 1'b1;
                          end else if (fall_evt) begin
                              nxt = S_QUIET;
                          end
                S_QUIET:  if (fall_evt) nxt = S_TAIL_A;
                S_TAIL_A: if (fall_evt) nxt = S_TAIL_B;
                S_TAIL_B: if (fall_evt) nxt = S_GAP;
                S_GAP:    if (fall_evt) nxt = S_IDLE;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Bit counter: cleared on each load, advanced on each shift.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_cnt <= '0;
        else if (load_en)  bit_cnt <= '0;
        else if (shift_en) bit_cnt <= bit_cnt + 1'b1;
    end

    // Done flag: set when the last bit leaves, cleared by the next load.
    always_ff @(posedge clk) begin
        if (!rst_n)                                done <= 1'b0;
        else if (load_en)                          done <= 1'b0;
        else if (state == S_SHIFT && nxt == S_MARK) done <= 1'b1;
    end

    // Decode the select and clock masks from the state.
    always_comb begin
        ss_act   = (state != S_IDLE) && (state != S_GAP);
        mask_ph1 = (state == S_ARM) || (state == S_SHIFT);
        mask_ph0 = (state == S_SHIFT);
    end

    assert_contention_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !contend_n |=> state == S_IDLE);
    assert_leave_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && $past(state) == S_IDLE) |-> $past(start && !xmit_empty && contend_n));
    assert_byte_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == S_SHIFT && state == S_MARK) |-> $past(bit_cnt) == LAST);

endmodule

// File: rtl/spi_xfer_seq.sv
// SPI master transfer sequencer, top level. It joins the divider, the
// sequencer and the shift register, and registers every bus pin so that
// SCK, MOSI and the selects leave the block with the same one-cycle delay.
// Assumes: configuration inputs stay steady during a transfer.
module spi_xfer_seq
    import spi_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SS_W   = 8,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              xmit_empty,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [SS_W-1:0]   ss_mask,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              contend_n,
    output logic              load_taken,
    output logic              done,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [SS_W-1:0]   ss_n,
    output logic              sck_oe,
    output logic              mosi_oe,
    output logic              ss_oe
);
    seq_state_t state;
    logic sck_int, rise_evt, fall_evt;
    logic load_en, shift_en, ss_act, mask_ph0, mask_ph1;
    logic sout, sck_raw, oe_q;

    spi_sck_div #(.SEL_W(DIV_W)) i_div (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .sck_int(sck_int), .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    spi_seq_fsm #(.W(DATA_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .xmit_empty(xmit_empty),
        .contend_n(contend_n), .cpha(cpha), .rise_evt(rise_evt), .fall_evt(fall_evt),
        .state(state), .load_en(load_en), .shift_en(shift_en), .ss_act(ss_act),
        .mask_ph0(mask_ph0), .mask_ph1(mask_ph1), .done(done)
    );

    spi_tx_shift #(.W(DATA_W)) i_shift (
        .clk(clk), .rst_n(rst_n), .load(load_en), .shift(shift_en),
        .din(tx_byte), .sout(sout)
    );

    // Choose the phase variant of the internal clock and apply the polarity.
    always_comb begin
        sck_raw = cpol ^ ((mask_ph1 && cpha && sck_int) || (mask_ph0 && !cpha && !sck_int));
    end

    // Register all pin outputs and the status signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck        <= 1'b0;
            mosi       <= 1'b0;
            ss_n       <= '1;
            oe_q       <= 1'b1;
            busy       <= 1'b0;
            load_taken <= 1'b0;
        end else begin
            sck        <= sck_raw;
            mosi       <= sout;
            ss_n       <= ~(ss_mask & {SS_W{ss_act}});
            oe_q       <= contend_n;
            busy       <= ss_act;
            load_taken <= load_en;
        end
    end

    assign sck_oe  = oe_q;
    assign mosi_oe = oe_q;
    assign ss_oe   = oe_q;

    assert_load_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_taken |=> !load_taken);
    assert_ss_steady_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != $past(sck)) |-> (ss_n == $past(ss_n)));
    assert_tristate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !contend_n |=> !(sck_oe || mosi_oe || ss_oe));
    assert_done_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> busy);

endmodule

// File: tb/test_spi_xfer_seq.sv
`timescale 1ns/1ps
module test_spi_xfer_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, xmit_empty = 1'b1, cpol = 1'b0, cpha = 1'b0, contend_n = 1'b1;
    logic [1:0] div_sel = 2'd0;
    logic [7:0] ss_mask = 8'h00, tx_byte = 8'h00;
    logic       load_taken, done, busy, sck, mosi, sck_oe, mosi_oe, ss_oe;
    logic [7:0] ss_n;

    int errors = 0, checks = 0;

    // observation state
    int   cyc, windows, nsamp, loads, lead_min, hold_min, gap_min, per, ss_bad, done_bad;
    int   t_fall, t_rise, last_edge, last_samp;
    bit   first_edge, seen_rise;
    logic prev_sck;
    logic [7:0]  prev_ssn, ss_or, cur_mask;
    logic [31:0] rx;
    logic [7:0]  txq [4];

    spi_xfer_seq i_spi_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .xmit_empty(xmit_empty),
        .cpol(cpol), .cpha(cpha), .div_sel(div_sel), .ss_mask(ss_mask),
        .tx_byte(tx_byte), .contend_n(contend_n), .load_taken(load_taken),
        .done(done), .busy(busy), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .sck_oe(sck_oe), .mosi_oe(mosi_oe), .ss_oe(ss_oe)
    );

    always #2.5 clk = ~clk;

    initial begin
        repeat (190000) @(posedge clk);
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        windows = 0; nsamp = 0; loads = 0; lead_min = 1 << 30; hold_min = 1 << 30;
        gap_min = 1 << 30; per = 0; ss_bad = 0; done_bad = 0; last_samp = 0;
        first_edge = 1'b0; seen_rise = 1'b0; ss_or = 8'h00; rx = '0;
        prev_sck = sck; prev_ssn = ss_n; last_edge = cyc; t_fall = cyc; t_rise = cyc;
    endtask

    // Called once per falling system clock edge: bus monitor.
    task automatic observe();
        cyc++;
        if (ss_n != 8'hFF && prev_ssn == 8'hFF) begin
            windows++; t_fall = cyc; first_edge = 1'b0;
            if (seen_rise && cyc - t_rise < gap_min) gap_min = cyc - t_rise;
        end
        if (ss_n != 8'hFF) begin
            ss_or |= ~ss_n;
            if (ss_n != ~cur_mask) ss_bad++;
        end
        if (sck != prev_sck) begin
            if (!first_edge && ss_n != 8'hFF) begin
                if (cyc - t_fall < lead_min) lead_min = cyc - t_fall;
                first_edge = 1'b1;
            end
            last_edge = cyc;
            if (sck == (cpol ^ ~cpha)) begin
                rx = {rx[30:0], mosi}; nsamp++;
                if (last_samp != 0) per = cyc - last_samp;
                last_samp = cyc;
            end
        end
        if (ss_n == 8'hFF && prev_ssn != 8'hFF) begin
            t_rise = cyc; seen_rise = 1'b1;
            if (cyc - last_edge < hold_min) hold_min = cyc - last_edge;
        end
        prev_sck = sck; prev_ssn = ss_n;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); observe();
        end
    endtask

    // Run n bytes from txq in the given mode, feeding on each load pulse.
    task automatic run_xfer(input logic c_pol, input logic c_pha, input logic [1:0] dv,
                            input logic [7:0] msk, input int n);
        int idx = 0;
        int guard = 0;
        cpol = c_pol; cpha = c_pha; div_sel = dv; ss_mask = msk; cur_mask = msk;
        idle_cycles(40);
        clear_stats();
        tx_byte = txq[0]; xmit_empty = 1'b0; start = 1'b1;
        while (!(idx == n && !busy && ss_n == 8'hFF) && guard < 30000) begin
            @(negedge clk); observe(); guard++;
            if (load_taken) begin
                loads++;
                if (done) done_bad++;
                idx++;
                if (idx < n) tx_byte = txq[idx];
                else begin xmit_empty = 1'b1; start = 1'b0; end
            end
        end
        idle_cycles(80);
    endtask

    task automatic t_reset();
        chk(sck == 1'b0, "R2", "sck idle after reset", sck, 0);
        chk(ss_n == 8'hFF, "R10", "selects high after reset", ss_n, 8'hFF);
        chk(busy == 1'b0 && done == 1'b0, "R9", "busy/done after reset", {busy, done}, 0);
        chk(load_taken == 1'b0, "R8", "no load after reset", load_taken, 0);
        chk(sck_oe && mosi_oe && ss_oe, "R11", "drivers enabled", {sck_oe, mosi_oe, ss_oe}, 7);
    endtask

    task automatic t_single_mode0();
        txq[0] = 8'hA5;
        run_xfer(1'b0, 1'b0, 2'd0, 8'h01, 1);
        chk(nsamp == 8, "R4", "mode0 sample count", nsamp, 8);
        chk(rx[7:0] == 8'hA5, "R4", "mode0 data MSB first", rx[7:0], 8'hA5);
        chk(lead_min >= 4, "R5", "mode0 select lead", lead_min, 4);
        chk(hold_min >= 8, "R6", "mode0 select hold", hold_min, 8);
        chk(ss_bad == 0 && ss_or == 8'h01, "R10", "mode0 select pattern", ss_or, 8'h01);
        chk(done == 1'b1 && busy == 1'b0, "R9", "done set, bus free", {done, busy}, 2);
        chk(sck == 1'b0, "R2", "mode0 idle level", sck, 0);
        chk(loads == 1, "R8", "one load pulse", loads, 1);
    endtask

    task automatic t_divs();
        for (int d = 0; d < 4; d++) begin
            txq[0] = 8'h5A ^ 8'(d * 17);
            run_xfer(1'b0, 1'b0, 2'(d), 8'h02, 1);
            chk(per == (4 << d), "R1", "sck period", per, 4 << d);
            chk(rx[7:0] == txq[0], "R4", "data at divider", rx[7:0], txq[0]);
            chk(nsamp == 8, "R2", "8 periods per byte", nsamp, 8);
        end
    endtask

    task automatic t_mode3_stream();
        txq[0] = 8'h3C; txq[1] = 8'hC3; txq[2] = 8'h81;
        run_xfer(1'b1, 1'b1, 2'd1, 8'h10, 3);
        chk(windows == 1, "R7", "cpha1 single select window", windows, 1);
        chk(nsamp == 24, "R4", "mode3 sample count", nsamp, 24);
        chk(rx[23:0] == 24'h3CC381, "R4", "mode3 stream data", rx[23:0], 24'h3CC381);
        chk(sck == 1'b1, "R2", "mode3 idle level", sck, 1);
        chk(loads == 3, "R8", "three load pulses", loads, 3);
        chk(done_bad == 0, "R9", "done clear at each load", done_bad, 0);
        chk(hold_min >= 16, "R6", "mode3 select hold", hold_min, 16);
        chk(lead_min >= 8, "R5", "mode3 select lead", lead_min, 8);
    endtask

    task automatic t_mode2_split();
        txq[0] = 8'h96; txq[1] = 8'h69;
        run_xfer(1'b1, 1'b0, 2'd2, 8'h04, 2);
        chk(windows == 2, "R7", "cpha0 reselect per byte", windows, 2);
        chk(gap_min >= 16, "R6", "select gap", gap_min, 16);
        chk(rx[15:0] == 16'h9669, "R4", "mode2 data", rx[15:0], 16'h9669);
        chk(done_bad == 0, "R9", "done clear at load", done_bad, 0);
    endtask

    task automatic t_mode1_multi();
        txq[0] = 8'hE1;
        run_xfer(1'b0, 1'b1, 2'd0, 8'h81, 1);
        chk(ss_bad == 0 && ss_or == 8'h81, "R10", "two selects together", ss_or, 8'h81);
        chk(rx[7:0] == 8'hE1, "R4", "mode1 data", rx[7:0], 8'hE1);
    endtask

    task automatic t_no_data();
        cpol = 1'b0; cpha = 1'b0; idle_cycles(10);
        clear_stats();
        xmit_empty = 1'b1; start = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); observe(); if (load_taken) loads++;
        end
        chk(windows == 0 && loads == 0, "R3", "start without data ignored", windows + loads, 0);
        start = 1'b0; xmit_empty = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk); observe(); if (load_taken) loads++;
        end
        chk(windows == 0 && loads == 0, "R3", "data without start ignored", windows + loads, 0);
        xmit_empty = 1'b1;
    endtask

    task automatic t_contention();
        int guard = 0;
        cpol = 1'b0; cpha = 1'b0; div_sel = 2'd2; ss_mask = 8'h01; cur_mask = 8'h01;
        tx_byte = 8'hFF; xmit_empty = 1'b0; start = 1'b1;
        while (!busy && guard < 1000) begin @(negedge clk); guard++; end
        repeat (20) @(negedge clk);
        contend_n = 1'b0;
        @(negedge clk);
        chk(!sck_oe && !mosi_oe && !ss_oe, "R11", "drivers off", {sck_oe, mosi_oe, ss_oe}, 0);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && ss_n == 8'hFF, "R11", "sequencer idle under contention", busy, 0);
        start = 1'b0; contend_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sck_oe && mosi_oe && ss_oe, "R11", "drivers back", {sck_oe, mosi_oe, ss_oe}, 7);
        repeat (100) @(negedge clk);
        chk(busy == 1'b0 && ss_n == 8'hFF, "R11", "stays idle without start", busy, 0);
        start = 1'b1;
        guard = 0;
        while (!busy && guard < 1000) begin @(negedge clk); guard++; end
        chk(busy == 1'b1, "R11", "restarts after release", busy, 1);
        xmit_empty = 1'b1; start = 1'b0;
        guard = 0;
        while (busy && guard < 2000) begin @(negedge clk); guard++; end
    endtask

    initial begin
        cyc = 0; cur_mask = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_mode0();
        t_divs();
        t_mode3_stream();
        t_mode2_split();
        t_mode1_multi();
        t_no_data();
        t_contention();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule